// File: doc/BRIEF.md
# SMBus Register-Access Target

This block is a two-wire serial target that lets a bus host read and write a bank of 8-bit registers kept outside the block. It oversamples the clock and data lines in the system clock domain. It finds start and stop conditions and decodes the address byte. It answers one fixed 7-bit address, 0x28, and drives the data line open-drain through a single output enable.

The same internal pointer serves every transaction. In a write, the first data byte after the address byte loads the pointer. Each byte after that is written to the register the pointer names, and the pointer then steps to the next register. A read returns the register at the pointer and steps the pointer after every byte, so reads run on through consecutive registers until the host answers a byte with a not-acknowledge. A repeated start keeps the pointer. This gives the usual set of transactions: set-pointer-only (Send Byte), read-at-pointer (Receive Byte), single and multi-byte writes, and set-pointer-then-read. Multi-byte transfers follow plain I2C framing. No count byte is decoded, so every data byte goes to the register bank.

The target never pulls the clock line low. Each response bit is set up from registered state within the same low phase of the clock.

Top module: `smbus_reg_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: An address byte whose upper seven bits differ from 0x28 gets no acknowledge. The target then leaves the data line released, makes no register writes and ignores all bytes until the next start condition.
- R3: An address byte whose upper seven bits are 0x28 is acknowledged: the target pulls the data line low for the ninth clock. Bit 0 of that byte selects the direction: 0 for a host write, 1 for a host read.
- R4: In a write transaction, the first data byte after the address byte is acknowledged and loads the register pointer (seen on `reg_addr`). It produces no register write.
- R5: Each later data byte in the same write is acknowledged and gives a one-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte received MSB first. `reg_addr` is one higher in the cycle after the pulse.
- R6: In a read transaction, the target shifts out `reg_rdata` for the pointer's register, MSB first, and steps the pointer after each byte.
- R7: When the host answers a read byte with a not-acknowledge (data line high in the ninth clock), the target releases the data line and drives nothing more until the next start.
- R8: A repeated start in the middle of a transaction begins a new address phase and keeps the pointer. This allows a pointer write followed by a read.
- R9: A stop condition (data rising while the clock is high) returns the target to idle from any state. Later clock pulses produce no drive and no writes.
- R10: `sda_oe` changes only while the synchronized clock line is low.
- R11: `reg_we` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level from the bus |
| sda_i | input | 1 | Serial data line level from the bus |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | PTR_W | Register pointer, used for both reads and writes |
| reg_wdata | output | 8 | Write data for the register bank |
| reg_rdata | input | 8 | Read data from the register bank at `reg_addr` |

## Verification
A wrong pointer or bit count shows up within one byte time. The ninth-clock acknowledge goes missing or appears in the wrong place, a read byte comes back with the wrong bits, or a write strobe lands on the wrong register. A state machine that fails to return to idle after a stop or a not-acknowledge is caught on the next clock pulse, because the target then pulls the line low or raises a stray write. A reference model tracks the expected pointer, bank contents and writes. On every system clock it compares any write strobe against the queue of expected writes, and it checks each bit the host samples against the model.

// File: rtl/smbus_tgt_pkg.sv
package smbus_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_HACK
  } tgt_state_t;
endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/smbus_cond_detect.sv
module smbus_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/smbus_tgt_fsm.sv
module smbus_tgt_fsm
  import smbus_tgt_pkg::*;
#(
  parameter int         PTR_W    = 8,
  parameter logic [6:0] TGT_ADDR = 7'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  tgt_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-2:0] tx_sh;
  logic [PTR_W-1:0]  ptr;
  logic              ptr_pend;
  logic              rw_q;
  logic              nack_q;

  assign reg_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      ptr_pend  <= 1'b0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      // pointer steps in the cycle after the strobe so the strobe sees the old value
      if (reg_we) ptr <= ptr + 1'b1;

      if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        ptr_pend <= 1'b1;
        sda_oe   <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              if (st == ST_ADDR) begin
                if (rx_sh[BYTE_W-1:1] == TGT_ADDR) begin
                  rw_q   <= rx_sh[0];
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                if (ptr_pend) begin
                  ptr      <= PTR_W'(rx_sh);
                  ptr_pend <= 1'b0;
                end else begin
                  reg_we    <= 1'b1;
                  reg_wdata <= rx_sh;
                end
                sda_oe <= 1'b1;
                st     <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                tx_sh  <= reg_rdata[BYTE_W-2:0];
                sda_oe <= ~reg_rdata[BYTE_W-1];
                cnt    <= CNT_W'(1);
                st     <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                st     <= ST_HACK;
              end else begin
                sda_oe <= ~tx_sh[BYTE_W-2];
                tx_sh  <= {tx_sh[BYTE_W-3:0], 1'b0};
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_HACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                st <= ST_IDLE;
              end else begin
                tx_sh  <= reg_rdata[BYTE_W-2:0];
                sda_oe <= ~reg_rdata[BYTE_W-1];
                cnt    <= CNT_W'(1);
                st     <= ST_RD;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R2 and R7: an idle target never holds the data line
  assert_idle_release_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);

  // R5: pointer is one higher in the cycle after a write strobe
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));

  // R9: a stop leaves the line released and no write pending
  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && !reg_we));

  // R10: drive changes only when the clock line was low
  assert_sda_low_phase_R10: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R11: the write strobe lasts one cycle
  assert_we_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
endmodule

// File: rtl/smbus_reg_target.sv
module smbus_reg_target
  import smbus_tgt_pkg::*;
#(
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] TGT_ADDR    = 7'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] sync_lines;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    smbus_line_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
    ) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(sync_lines[g])
    );
  end

  smbus_cond_detect u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (sync_lines[0]),
    .sda_s    (sync_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  smbus_tgt_fsm #(
    .PTR_W   (PTR_W),
    .TGT_ADDR(TGT_ADDR)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (sync_lines[0]),
    .sda_s    (sync_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .reg_rdata(reg_rdata),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
  );
endmodule

// File: tb/test_smbus_reg_target.sv
module test_smbus_reg_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_line;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] exp_q [$];

  int n_tests = 0;
  int n_fail  = 0;
  int r10_viol = 0;
  int stray_we = 0;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  assign sda_line  = sda_h & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  smbus_reg_target i_smbus_reg_target (
    .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // register bank behind the target
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of write strobes against the model queue (R5, R11, R10)
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we) begin
        if (exp_q.size() == 0) begin
          stray_we++;
          chk(0, "R5 unexpected write", {reg_addr, reg_wdata}, 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({reg_addr, reg_wdata} == e, "R5 write addr/data", {reg_addr, reg_wdata}, e);
        end
      end
      if (sda_oe != prev_oe && scl_h) r10_viol++;
      prev_oe = sda_oe;
    end
  end

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wait_q(Q);
    scl_h = 1'b1; wait_q(Q);
    sda_h = 1'b0; wait_q(Q);
    scl_h = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wait_q(Q);
    scl_h = 1'b1; wait_q(Q);
    sda_h = 1'b1; wait_q(Q);
  endtask

  task automatic clk_bit(input bit b, output bit seen);
    sda_h = b;    wait_q(Q);
    scl_h = 1'b1; wait_q(Q);
    seen = sda_line;
    wait_q(Q);
    scl_h = 1'b0;
  endtask

  task automatic host_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    chk((!s) == exp_ack, tag, !s, exp_ack);
  endtask

  task automatic expect_write(input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    exp_mem[a] = d;
  endtask

  task automatic host_read(input logic [7:0] exp, input bit nack, input string tag);
    bit s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      got[i] = s;
    end
    chk(got == exp, tag, got, exp);
    clk_bit(nack, s);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    bit s;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i) ^ 8'h3C;
      exp_mem[i] = 8'(i) ^ 8'h3C;
    end
    wait_q(6);
    rst = 1'b0;
    wait_q(2);
    // R1
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(reg_we == 1'b0, "R1 reg_we after reset", reg_we, 0);
    chk(reg_addr == 8'h00, "R1 reg_addr after reset", reg_addr, 0);

    // Write Byte: R3 R4 R5
    bus_start();
    host_byte(8'h50, 1'b1, "R3 own address write acked");
    host_byte(8'h10, 1'b1, "R4 pointer byte acked");
    chk(reg_addr == 8'h10, "R4 pointer loaded", reg_addr, 8'h10);
    chk(exp_q.size() == 0 && stray_we == 0, "R4 no write for pointer byte", stray_we, 0);
    expect_write(8'h10, 8'hA5);
    host_byte(8'hA5, 1'b1, "R5 data byte acked");
    bus_stop();
    chk(reg_addr == 8'h11, "R5 pointer stepped", reg_addr, 8'h11);

    // multi-byte write, I2C framing: R5
    bus_start();
    host_byte(8'h50, 1'b1, "R3 ack block write");
    host_byte(8'h20, 1'b1, "R4 block pointer");
    expect_write(8'h20, 8'h01); host_byte(8'h01, 1'b1, "R5 block byte 0");
    expect_write(8'h21, 8'h82); host_byte(8'h82, 1'b1, "R5 block byte 1");
    expect_write(8'h22, 8'hFF); host_byte(8'hFF, 1'b1, "R5 block byte 2");
    bus_stop();
    chk(exp_q.size() == 0, "R5 all block writes seen", exp_q.size(), 0);

    // pointer then repeated start read: R8 R6 R7
    bus_start();
    host_byte(8'h50, 1'b1, "R3 ack before restart");
    host_byte(8'h10, 1'b1, "R8 pointer before restart");
    bus_start();
    host_byte(8'h51, 1'b1, "R3 own address read acked");
    host_read(exp_mem[8'h10], 1'b1, "R6 read byte after restart");
    wait_q(Q);
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    bus_stop();
    chk(reg_addr == 8'h11, "R6 pointer after single read", reg_addr, 8'h11);

    // multi-byte read: R6 R8
    bus_start();
    host_byte(8'h50, 1'b1, "R3 ack block read setup");
    host_byte(8'h20, 1'b1, "R8 block read pointer");
    bus_start();
    host_byte(8'h51, 1'b1, "R3 ack block read");
    host_read(exp_mem[8'h20], 1'b0, "R6 block read 0");
    host_read(exp_mem[8'h21], 1'b0, "R6 block read 1");
    host_read(exp_mem[8'h22], 1'b1, "R6 block read 2");
    bus_stop();

    // read at current pointer (0x23), no pointer write: R6
    bus_start();
    host_byte(8'h51, 1'b1, "R3 ack receive byte");
    host_read(exp_mem[8'h23], 1'b1, "R6 receive byte at 0x23");
    bus_stop();

    // pointer-only write: R4
    bus_start();
    host_byte(8'h50, 1'b1, "R3 ack send byte");
    host_byte(8'h30, 1'b1, "R4 send byte acked");
    bus_stop();
    chk(reg_addr == 8'h30, "R4 send byte sets pointer", reg_addr, 8'h30);

    // foreign addresses: R2
    bus_start();
    host_byte(8'h52, 1'b0, "R2 foreign write address not acked");
    host_byte(8'h40, 1'b0, "R2 ignored byte 0");
    host_byte(8'h77, 1'b0, "R2 ignored byte 1");
    bus_stop();
    chk(reg_addr == 8'h30 && stray_we == 0, "R2 no pointer or write change", reg_addr, 8'h30);
    bus_start();
    host_byte(8'h53, 1'b0, "R2 foreign read address not acked");
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      chk(s == 1'b1, "R2 no drive after foreign read", s, 1);
    end
    bus_stop();

    // stop in the middle of a byte: R9
    bus_start();
    host_byte(8'h50, 1'b1, "R3 ack before aborted write");
    host_byte(8'h40, 1'b1, "R4 pointer before abort");
    clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    bus_stop();
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      chk(s == 1'b1, "R9 line free after stop", s, 1);
    end
    chk(stray_we == 0 && exp_q.size() == 0, "R9 no write after stop", stray_we, 0);
    // confirm register 0x40 still holds its reset contents (R2, R9)
    bus_start();
    host_byte(8'h51, 1'b1, "R3 ack final read");
    host_read(exp_mem[8'h40], 1'b1, "R9 register 0x40 untouched");
    bus_stop();

    wait_q(4);
    chk(r10_viol == 0, "R10 drive changed with clock high", r10_viol, 0);
    chk(exp_q.size() == 0, "R11 every expected write seen once", exp_q.size(), 0);
    finish_run();
  end
endmodule